// File: doc/BRIEF.md
# Two-Stage Locked Watchdog Timer

This block is a register-mapped watchdog with two countdown stages that share one 20-bit down-counter. A prescaler turns the bus clock into a slow tick, and the counter decrements on that tick. The counter first runs down the stage-one preload. When that stage expires, the block latches an interrupt status bit, may drive an interrupt, and loads the stage-two preload. When stage two expires in watchdog mode, the block sets a sticky timeout flag and may issue a single-cycle reset request. The countdown then wraps back to stage one.

Software keeps the system alive by restarting the countdown before stage two runs out. The two preload registers and the reload register are protected. Each write to one of them must follow a two-word unlock sequence. A lock bit, once set, holds the watchdog enabled until the block's own hardware reset. Delivering the interrupt and the system reset lies outside this block; it only drives the two request outputs.

Register offsets:
- 0x00: stage-one preload (protected).
- 0x04: stage-two preload (protected).
- 0x08: status.
- 0x0C: reload (protected).
- 0x10: configuration.
- 0x14: lock.
- 0x18: live count, read-only.

Top module: `dual_stage_watchdog`

## Requirements
- R1: A protected register is written only after two writes to offset 0x0C carrying exactly 0x0000_0080 and then 0x0000_0086. A protected write with no such pair is ignored, and so is one where any other write came between the two words.
- R2: One unlock pair admits exactly one protected write. A second protected write without a new pair is ignored.
- R3: An admitted write to 0x0C with bit 8 set does three things: it reloads the counter from the stage-one preload, clears the prescaler, and returns to stage one. Restarts issued often enough prevent any expiry.
- R4: After a restart, stage one expires on tick number preload1+1. That expiry sets status bit 0 (offset 0x08) and loads the counter with preload2. Stage two expires preload2+1 ticks later.
- R5: Lock register 0x14 holds three bits: bit 0 is the lock, bit 1 is the enable, and bit 2 is the mode (0 = watchdog, 1 = timer). Once the lock is set, the enable bit cannot be cleared and the mode is frozen. The lock bit is cleared only by the hardware reset.
- R6: A stage-two expiry in watchdog mode sets a sticky flag, read as bit 9 of 0x0C. When configuration bit 5 is set, the same expiry also raises rst_req_o for exactly one cycle. The flag survives a disable and re-enable. An admitted write to 0x0C with bit 9 set clears the flag.
- R7: Configuration bits [1:0] select the interrupt type. 00 gives a level interrupt that follows status bit 0; writing 1 to bit 0 of 0x08 clears that status bit. 01 gives a one-cycle pulse at stage-one expiry. 1x gives no interrupt.
- R8: While the enable bit is 0, the counter and prescaler hold and no expiry occurs. Offset 0x18 reads the counter.
- R9: The tick period is 2^SLOW_EXP clocks when configuration bit 2 is 0, and 2^FAST_EXP clocks when it is 1.
- R10: In timer mode, a stage-two expiry sets no flag and raises no reset request. The countdown wraps to the stage-one preload.
- R11: When an admitted restart lands on the same clock edge as an expiry, the restart wins: no flag, no reset request, and the counter is loaded with preload1.
- R12: Reset state:
  - both preloads equal PRE_RST;
  - status, flag, configuration and lock register all read 0;
  - irq_o and rst_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | AW | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 1 | Stage-one interrupt request |
| rst_req_o | output | 1 | Stage-two reset request pulse |

## Verification
The risky overlap is a software restart that is admitted on the very edge where stage two would expire. The bench tracks the tick phase from the restart edge, so it knows which edge carries the expiry. It places the two unlock words on the two edges before that one and the restart on the expiry edge itself. The outcome is judged at the ports: the reset request stays low, the sticky flag reads 0, and the count register shows the stage-one preload.

// File: rtl/dswd_pkg.sv
package dswd_pkg;

  typedef enum logic [1:0] {
    GATE_IDLE = 2'd0,
    GATE_HALF = 2'd1,
    GATE_OPEN = 2'd2
  } gate_e;

  localparam int unsigned OFF_PRE1   = 'h00;
  localparam int unsigned OFF_PRE2   = 'h04;
  localparam int unsigned OFF_STAT   = 'h08;
  localparam int unsigned OFF_RELOAD = 'h0C;
  localparam int unsigned OFF_CFG    = 'h10;
  localparam int unsigned OFF_LOCK   = 'h14;
  localparam int unsigned OFF_COUNT  = 'h18;

  localparam logic [31:0] KEY_FIRST  = 32'h0000_0080;
  localparam logic [31:0] KEY_SECOND = 32'h0000_0086;

  localparam int RELOAD_BIT = 8;
  localparam int FLAG_BIT   = 9;

  function automatic gate_e gate_next(gate_e st, logic wr, logic k1, logic k2, logic prot);
    gate_e n;
    n = st;
    if (wr) begin
      case (st)
        GATE_IDLE: n = k1 ? GATE_HALF : GATE_IDLE;
        GATE_HALF: n = k2 ? GATE_OPEN : (k1 ? GATE_HALF : GATE_IDLE);
        GATE_OPEN: n = prot ? GATE_IDLE : GATE_OPEN;
        default:   n = GATE_IDLE;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/dswd_unlock_gate.sv
module dswd_unlock_gate
  import dswd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_is_reload,
  input  logic        wr_is_prot,
  input  logic [31:0] wr_data,
  output logic        prot_accept,
  output logic        gate_open
);

  gate_e st_q;
  logic  key1, key2;

  assign key1 = wr_is_reload && (wr_data == KEY_FIRST);
  assign key2 = wr_is_reload && (wr_data == KEY_SECOND);

  assign gate_open   = (st_q == GATE_OPEN);
  assign prot_accept = wr_en && wr_is_prot && gate_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= GATE_IDLE;
    else        st_q <= gate_next(st_q, wr_en, key1, key2, wr_is_prot);
  end

  AST_GATE_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    prot_accept |=> !gate_open); // R2

  AST_GATE_FROM_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_open) |-> ($past(st_q) == GATE_HALF)); // R1

endmodule

// File: rtl/dswd_prescaler.sv
module dswd_prescaler #(
  parameter int SLOW_EXP = 15,
  parameter int FAST_EXP = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  input  logic fast,
  output logic tick
);

  localparam int PW = (SLOW_EXP > FAST_EXP) ? SLOW_EXP : FAST_EXP;
  localparam logic [PW-1:0] SLOW_LIM = {PW{1'b1}} >> (PW - SLOW_EXP);
  localparam logic [PW-1:0] FAST_LIM = {PW{1'b1}} >> (PW - FAST_EXP);

  logic [PW-1:0] ps_q;

  function automatic logic [PW-1:0] limit_for(logic use_fast);
    return use_fast ? FAST_LIM : SLOW_LIM;
  endfunction

  assign tick = run && (ps_q >= limit_for(fast));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       ps_q <= '0;
    else if (clear || !run || tick)   ps_q <= '0;
    else                              ps_q <= ps_q + 1'b1;
  end

  AST_PS_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (ps_q == '0)); // R8

endmodule

// File: rtl/dswd_countdown.sv
module dswd_countdown #(
  parameter int CW = 20,
  parameter logic [CW-1:0] PRE_RST = 20'h00400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          restart,
  input  logic [CW-1:0] pre1,
  input  logic [CW-1:0] pre2,
  output logic [CW-1:0] cnt_o,
  output logic          st1_exp,
  output logic          st2_exp
);

  logic [CW-1:0] cnt_q;
  logic          stage2_q;
  logic          step, zero;

  function automatic logic [CW-1:0] dec1(logic [CW-1:0] v);
    return v - 1'b1;
  endfunction

  assign zero    = (cnt_q == '0);
  assign step    = run && tick && !restart;
  assign st1_exp = step && zero && !stage2_q;
  assign st2_exp = step && zero && stage2_q;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= PRE_RST;
      stage2_q <= 1'b0;
    end else if (restart) begin
      cnt_q    <= pre1;
      stage2_q <= 1'b0;
    end else if (step) begin
      if (zero) begin
        cnt_q    <= stage2_q ? pre1 : pre2;
        stage2_q <= !stage2_q;
      end else begin
        cnt_q    <= dec1(cnt_q);
      end
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(cnt_q)); // R8

  AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == $past(pre1)) && !stage2_q); // R11

endmodule

// File: rtl/dual_stage_watchdog.sv
module dual_stage_watchdog
  import dswd_pkg::*;
#(
  parameter int AW = 5,
  parameter int CW = 20,
  parameter int SLOW_EXP = 15,
  parameter int FAST_EXP = 5,
  parameter logic [CW-1:0] PRE_RST = 20'h00400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic          irq_o,
  output logic          rst_req_o
);

  localparam int NPRE = 2;

  logic [CW-1:0] pre_q [NPRE];
  logic [5:0]    cfg_q;
  logic          lock_q, en_q, mode_q;
  logic          stat_q, flag_q, rst_req_q, irq_pulse_q;

  logic w_pre1, w_pre2, w_reload, w_prot, w_stat, w_cfg, w_lock;
  logic prot_accept, gate_open;
  logic restart_ev, flag_clr_ev, tick;
  logic st1_exp, st2_exp;
  logic [CW-1:0] cnt;
  logic          cfg_rst_en, cfg_fast;
  logic [1:0]    cfg_itype;

  assign w_pre1   = (wr_addr == AW'(OFF_PRE1));
  assign w_pre2   = (wr_addr == AW'(OFF_PRE2));
  assign w_reload = (wr_addr == AW'(OFF_RELOAD));
  assign w_stat   = (wr_addr == AW'(OFF_STAT));
  assign w_cfg    = (wr_addr == AW'(OFF_CFG));
  assign w_lock   = (wr_addr == AW'(OFF_LOCK));
  assign w_prot   = w_pre1 || w_pre2 || w_reload;

  assign cfg_rst_en = cfg_q[5];
  assign cfg_fast   = cfg_q[2];
  assign cfg_itype  = cfg_q[1:0];

  dswd_unlock_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_is_reload (w_reload),
    .wr_is_prot   (w_prot),
    .wr_data      (wr_data),
    .prot_accept  (prot_accept),
    .gate_open    (gate_open)
  );

  assign restart_ev  = prot_accept && w_reload && wr_data[RELOAD_BIT];
  assign flag_clr_ev = prot_accept && w_reload && wr_data[FLAG_BIT];

  genvar gi;
  generate
    for (gi = 0; gi < NPRE; gi++) begin : g_pre
      logic sel;
      assign sel = (gi == 0) ? w_pre1 : w_pre2;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   pre_q[gi] <= PRE_RST;
        else if (prot_accept && sel)  pre_q[gi] <= wr_data[CW-1:0];
      end
    end
  endgenerate

  dswd_prescaler #(.SLOW_EXP(SLOW_EXP), .FAST_EXP(FAST_EXP)) u_ps (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (en_q),
    .clear (restart_ev),
    .fast  (cfg_fast),
    .tick  (tick)
  );

  dswd_countdown #(.CW(CW), .PRE_RST(PRE_RST)) u_cd (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en_q),
    .tick    (tick),
    .restart (restart_ev),
    .pre1    (pre_q[0]),
    .pre2    (pre_q[1]),
    .cnt_o   (cnt),
    .st1_exp (st1_exp),
    .st2_exp (st2_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      lock_q <= 1'b0;
      en_q   <= 1'b0;
      mode_q <= 1'b0;
    end else if (wr_en) begin
      if (w_cfg) cfg_q <= wr_data[5:0] & 6'b100111;
      if (w_lock) begin
        lock_q <= lock_q | wr_data[0];
        en_q   <= wr_data[1] | (lock_q & en_q);
        mode_q <= lock_q ? mode_q : wr_data[2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q      <= 1'b0;
      flag_q      <= 1'b0;
      rst_req_q   <= 1'b0;
      irq_pulse_q <= 1'b0;
    end else begin
      if (st1_exp)                             stat_q <= 1'b1;
      else if (wr_en && w_stat && wr_data[0])  stat_q <= 1'b0;
      if (st2_exp && !mode_q)                  flag_q <= 1'b1;
      else if (flag_clr_ev)                    flag_q <= 1'b0;
      rst_req_q   <= st2_exp && !mode_q && cfg_rst_en;
      irq_pulse_q <= st1_exp && (cfg_itype == 2'b01);
    end
  end

  assign rst_req_o = rst_req_q;
  assign irq_o     = (cfg_itype == 2'b00) ? stat_q :
                     (cfg_itype == 2'b01) ? irq_pulse_q : 1'b0;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AW'(OFF_PRE1):   rd_data[CW-1:0]   = pre_q[0];
      AW'(OFF_PRE2):   rd_data[CW-1:0]   = pre_q[1];
      AW'(OFF_STAT):   rd_data[0]        = stat_q;
      AW'(OFF_RELOAD): rd_data[FLAG_BIT] = flag_q;
      AW'(OFF_CFG):    rd_data[5:0]      = cfg_q;
      AW'(OFF_LOCK):   rd_data[2:0]      = {mode_q, en_q, lock_q};
      AW'(OFF_COUNT):  rd_data[CW-1:0]   = cnt;
      default:         rd_data           = '0;
    endcase
  end

  AST_LOCK_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && en_q) |=> (lock_q && en_q)); // R5

  AST_RST_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> flag_q); // R6

  AST_NO_EXPIRY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!st1_exp && !st2_exp)); // R8

  AST_TIMER_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |=> !rst_req_o); // R10

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o); // R6

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse_q |=> !irq_pulse_q); // R7

endmodule

// File: tb/dual_stage_watchdog_bench.sv
`timescale 1ns/100ps
module dual_stage_watchdog_bench;

  localparam int AW = 5;
  localparam int CW = 20;
  localparam int SLOW_EXP = 4;
  localparam int FAST_EXP = 2;
  localparam logic [CW-1:0] PRE_RST = 20'h00400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic          irq_o, rst_req_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  dual_stage_watchdog #(.AW(AW), .CW(CW), .SLOW_EXP(SLOW_EXP), .FAST_EXP(FAST_EXP),
                        .PRE_RST(PRE_RST)) u_dual_stage_watchdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic edges(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a[AW-1:0]; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pwr(logic [7:0] a, logic [31:0] d);
    wr(8'h0C, 32'h80);
    wr(8'h0C, 32'h86);
    wr(a, d);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    rd_addr = a[AW-1:0];
    #1;
    d = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0;
    edges(2);
    rst_n = 1'b1;
    edges(1);
  endtask

  // returns one time unit after the restart edge
  task automatic setup(logic [31:0] p1, logic [31:0] p2, logic [31:0] cfg, logic [31:0] lk);
    do_reset();
    pwr(8'h00, p1);
    pwr(8'h04, p2);
    wr(8'h10, cfg);
    wr(8'h14, lk);
    pwr(8'h0C, 32'h100);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R12", "irq", {31'b0, irq_o}, 0);
    chk("R12", "rst_req", {31'b0, rst_req_o}, 0);
    rd(8'h00, v); chk("R12", "pre1", v, 32'(PRE_RST));
    rd(8'h04, v); chk("R12", "pre2", v, 32'(PRE_RST));
    edges(1);
    rd(8'h08, v); chk("R12", "status", v, 0);
    rd(8'h0C, v); chk("R12", "flag", v, 0);
    edges(1);
    rd(8'h10, v); chk("R12", "cfg", v, 0);
    rd(8'h14, v); chk("R12", "lock", v, 0);
  endtask

  task automatic t_unlock();
    do_reset();
    wr(8'h00, 32'd5);
    rd(8'h00, v); chk("R1", "write w/o unlock", v, 32'(PRE_RST));
    wr(8'h0C, 32'h80); wr(8'h08, 32'h0); wr(8'h0C, 32'h86); wr(8'h00, 32'd7);
    rd(8'h00, v); chk("R1", "broken sequence", v, 32'(PRE_RST));
    pwr(8'h00, 32'd9);
    rd(8'h00, v); chk("R1", "unlocked write", v, 32'd9);
    wr(8'h00, 32'd11);
    rd(8'h00, v); chk("R2", "second write", v, 32'd9);
  endtask

  task automatic t_lock();
    do_reset();
    wr(8'h14, 32'h3);
    rd(8'h14, v); chk("R5", "lock+en", v, 32'h3);
    wr(8'h14, 32'h0);
    rd(8'h14, v); chk("R5", "clear attempt", v, 32'h3);
    wr(8'h14, 32'h4);
    rd(8'h14, v); chk("R5", "mode frozen", v, 32'h3);
    do_reset();
    rd(8'h14, v); chk("R5", "after hw reset", v, 32'h0);
  endtask

  task automatic t_expiry();
    setup(32'd3, 32'd2, 32'h24, 32'h2);
    rd(8'h18, v); chk("R3", "count after restart", v, 32'd3);
    edges(15);
    chk("R4", "irq before st1", {31'b0, irq_o}, 0);
    edges(1);
    chk("R4", "irq at st1", {31'b0, irq_o}, 1);
    rd(8'h18, v); chk("R4", "count=pre2", v, 32'd2);
    rd(8'h08, v); chk("R4", "status", v, 32'd1);
    edges(11);
    chk("R4", "rst before st2", {31'b0, rst_req_o}, 0);
    edges(1);
    chk("R6", "rst at st2", {31'b0, rst_req_o}, 1);
    rd(8'h0C, v); chk("R6", "flag set", v, 32'h200);
    edges(1);
    chk("R6", "rst one cycle", {31'b0, rst_req_o}, 0);
    wr(8'h08, 32'h1);
    chk("R7", "level irq cleared", {31'b0, irq_o}, 0);
    wr(8'h14, 32'h0); wr(8'h14, 32'h2);
    rd(8'h0C, v); chk("R6", "flag survives", v, 32'h200);
    pwr(8'h0C, 32'h200);
    rd(8'h0C, v); chk("R6", "flag cleared", v, 32'h0);
  endtask

  task automatic t_keepalive();
    setup(32'd3, 32'd2, 32'h24, 32'h2);
    for (int i = 0; i < 4; i++) begin
      edges(12);
      pwr(8'h0C, 32'h100);
      rd(8'h18, v); chk("R3", "count reloaded", v, 32'd3);
    end
    chk("R3", "no irq", {31'b0, irq_o}, 0);
    rd(8'h08, v); chk("R3", "no status", v, 0);
  endtask

  task automatic t_disabled();
    do_reset();
    pwr(8'h00, 32'd3);
    wr(8'h10, 32'h04);
    pwr(8'h0C, 32'h100);
    edges(40);
    rd(8'h18, v); chk("R8", "count held", v, 32'd3);
    chk("R8", "no irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_itype();
    setup(32'd1, 32'd50, 32'h05, 32'h2);
    edges(7);
    chk("R7", "pulse before", {31'b0, irq_o}, 0);
    edges(1);
    chk("R7", "pulse high", {31'b0, irq_o}, 1);
    edges(1);
    chk("R7", "pulse low", {31'b0, irq_o}, 0);
    rd(8'h08, v); chk("R7", "status kept", v, 1);
    wr(8'h10, 32'h07);
    chk("R7", "type none", {31'b0, irq_o}, 0);
  endtask

  task automatic t_slow();
    setup(32'd1, 32'd50, 32'h00, 32'h2);
    edges(31);
    chk("R9", "slow before", {31'b0, irq_o}, 0);
    edges(1);
    chk("R9", "slow expiry", {31'b0, irq_o}, 1);
  endtask

  task automatic t_modes();
    setup(32'd1, 32'd1, 32'h24, 32'h6);
    edges(16);
    chk("R10", "timer no rst", {31'b0, rst_req_o}, 0);
    rd(8'h0C, v); chk("R10", "timer no flag", v, 0);
    rd(8'h18, v); chk("R10", "wrap to pre1", v, 32'd1);
    setup(32'd1, 32'd1, 32'h04, 32'h2);
    edges(16);
    chk("R6", "rst disabled", {31'b0, rst_req_o}, 0);
    rd(8'h0C, v); chk("R6", "flag w/o rst", v, 32'h200);
  endtask

  task automatic t_collide();
    setup(32'd3, 32'd2, 32'h24, 32'h2);
    edges(25);
    wr(8'h0C, 32'h80);
    wr(8'h0C, 32'h86);
    wr(8'h0C, 32'h100);   // admitted on the stage-two expiry edge
    chk("R11", "no rst", {31'b0, rst_req_o}, 0);
    rd(8'h0C, v); chk("R11", "no flag", v, 0);
    rd(8'h18, v); chk("R11", "count=pre1", v, 32'd3);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_unlock();
    t_lock();
    t_expiry();
    t_keepalive();
    t_disabled();
    t_itype();
    t_slow();
    t_modes();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule